// File: doc/BRIEF.md
# Memory Command Issuer with Send Backpressure

This block sits between a load/store unit and a memory port. It takes one pending memory request at a time and turns it into a 3-bit bus command. The command depends on whether the request is a read or a write and on its atomic attributes: load-linked/store-conditional and swap. It then offers the command to the downstream port and reports completion back to the requester.

A store-conditional that has lost its reservation never reaches memory. The block reports it complete at once, with a failure status. The reservation tracking logic is outside the block and is seen only through a single link-valid input.

If the port refuses a command, the block enters a blocked state. In that state it offers nothing and accepts no new request until the port signals a retry. When a command is accepted, the request waits for the memory response before it is reported done.

Top module: `mem_cmd_issuer`

## Requirements
- R1: A read (`req_write`=0) with `req_llsc`=1 is offered as code 2 (load-locked). A read with `req_llsc`=0 is offered as code 0 (plain read).
- R2: A write with `req_swap`=1 is offered as code 4 (swap), whatever the value of `req_llsc`.
- R3: A write with `req_swap`=0 and `req_llsc`=0 is offered as code 1 (plain write).
- R4: A store-conditional (write, `req_llsc`=1, `req_swap`=0) that arrives while `link_ok`=0 never raises `cmd_valid`. It raises `done_valid` with `done_fail`=1 in the cycle after the request is taken.
- R5: When `cmd_valid`=1 and `cmd_accept`=0, the block becomes blocked in the next cycle. While blocked, `cmd_valid` is 0 and the request stays incomplete, so `done_valid` is 0.
- R6: While blocked, `req_ready` is 0 and no new request is taken.
- R7: A `port_retry` pulse while blocked re-offers the same command in the next cycle. A `port_retry` while not blocked raises `retry_err` for one cycle in the next cycle and changes nothing else.
- R8: After an accepted command, the request stays pending with `done_valid`=0 until `mem_resp` arrives. `done_valid`=1 with `done_fail`=0 follows one cycle after `mem_resp`, and `req_ready` returns one cycle after that.
- R9: After reset, `req_ready`=1, and `cmd_valid`, `done_valid` and `retry_err` are all 0.
- R10: A store-conditional taken while `link_ok`=1 is offered as code 3 and completes with `done_fail`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block takes the request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_llsc | input | 1 | Load-linked / store-conditional attribute |
| req_swap | input | 1 | Swap attribute |
| link_ok | input | 1 | The reservation is still held |
| cmd_valid | output | 1 | A command is offered to the port |
| cmd_code | output | 3 | Command: 0 read, 1 write, 2 load-locked, 3 store-conditional, 4 swap |
| cmd_accept | input | 1 | The port takes the offered command |
| port_retry | input | 1 | The port can now take a refused command |
| mem_resp | input | 1 | Memory response for the pending command |
| done_valid | output | 1 | The request is complete |
| done_fail | output | 1 | 1 when a store-conditional failed |
| retry_err | output | 1 | A retry arrived while not blocked |

## Verification
A request taken at one clock edge appears as an offered command one cycle later. A locally failed store-conditional shows completion at that same point instead. A refusal, a retry or a memory response takes effect at the next edge, and completion stays visible for exactly one cycle.

The bench drives every input at the falling edge. It samples the outputs at the following falling edge, after the one rising edge that must have moved them. It also checks one cycle later that `done_valid` and `retry_err` have dropped again.

// File: rtl/mem_cmd_pkg.sv
// Shared types for the memory command issuer.
// Assumes a 3-bit command field decoded by the downstream port.
package mem_cmd_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CMD_READ  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_LDLK  = 3'd2,
        CMD_STCND = 3'd3,
        CMD_SWAP  = 3'd4
    } mem_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEND    = 3'd1,
        ST_BLOCKED = 3'd2,
        ST_PENDING = 3'd3,
        ST_DONE    = 3'd4
    } issue_state_e;
endpackage

// File: rtl/mem_cmd_encoder.sv
// Combinational encoder: maps the operation and its atomic attributes to a command code.
// Swap takes precedence over the LL/SC attribute on writes; reads ignore swap.
module mem_cmd_encoder
    import mem_cmd_pkg::*;
(
    input  logic     is_write,
    input  logic     llsc,
    input  logic     swap,
    output mem_cmd_e code,
    output logic     is_stcond
);
    // Purpose: choose the command code for the request.
    always_comb begin
        is_stcond = 1'b0;
        if (!is_write) begin
            code = llsc ? CMD_LDLK : CMD_READ;
        end else if (swap) begin
            code = CMD_SWAP;
        end else if (llsc) begin
            code      = CMD_STCND;
            is_stcond = 1'b1;
        end else begin
            code = CMD_WRITE;
        end
    end
endmodule

// File: rtl/mem_issue_fsm.sv
// Issue sequencer: takes one request, offers its command, tracks a refusal as a
// blocked state cleared only by retry, waits for the response, reports completion.
// Assumes the requester holds its fields stable while req_valid is high.
module mem_issue_fsm
    import mem_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  mem_cmd_e            enc_code,
    input  logic                enc_stcond,
    input  logic                link_ok,
    output logic                cmd_valid,
    output logic [CODE_W-1:0]   cmd_code,
    input  logic                cmd_accept,
    input  logic                port_retry,
    input  logic                mem_resp,
    output logic                done_valid,
    output logic                done_fail,
    output logic                retry_err
);
    issue_state_e state_q, state_d;
    mem_cmd_e     code_q, code_d;
    logic         fail_q, fail_d;

    // Purpose: next-state and output decode.
    always_comb begin
        state_d    = state_q;
        code_d     = code_q;
        fail_d     = fail_q;
        req_ready  = 1'b0;
        cmd_valid  = 1'b0;
        done_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    code_d = enc_code;
                    if (enc_stcond && !link_ok) begin
                        fail_d  = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        fail_d  = 1'b0;
                        state_d = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                cmd_valid = 1'b1;
                state_d   = cmd_accept ? ST_PENDING : ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (port_retry) state_d = ST_SEND;
            end
            ST_PENDING: begin
                if (mem_resp) state_d = ST_DONE;
            end
            ST_DONE: begin
                done_valid = 1'b1;
                state_d    = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cmd_code  = code_q;
    assign done_fail = done_valid & fail_q;

    // Purpose: state, captured command and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            code_q    <= CMD_READ;
            fail_q    <= 1'b0;
            retry_err <= 1'b0;
        end else begin
            state_q   <= state_d;
            code_q    <= code_d;
            fail_q    <= fail_d;
            retry_err <= port_retry && (state_q != ST_BLOCKED);
        end
    end

    assert_sc_fail_local_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && enc_stcond && !link_ok)
        |=> (done_valid && done_fail && !cmd_valid));

    assert_refuse_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_accept) |=> (state_q == ST_BLOCKED && !done_valid));

    assert_blocked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED) |-> (!cmd_valid && !req_ready));

    assert_retry_reissues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLOCKED && port_retry) |=> (cmd_valid && $stable(cmd_code)));

    assert_accept_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_accept) |=> (!done_valid && !cmd_valid && !req_ready));
endmodule

// File: rtl/mem_cmd_issuer.sv
// Top: memory command issuer with send backpressure.
// Joins the command encoder and the issue sequencer; one request in flight at a time.
module mem_cmd_issuer
    import mem_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_llsc,
    input  logic              req_swap,
    input  logic              link_ok,
    output logic              cmd_valid,
    output logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_accept,
    input  logic              port_retry,
    input  logic              mem_resp,
    output logic              done_valid,
    output logic              done_fail,
    output logic              retry_err
);
    mem_cmd_e enc_code;
    logic     enc_stcond;

    mem_cmd_encoder u_enc (
        .is_write  (req_write),
        .llsc      (req_llsc),
        .swap      (req_swap),
        .code      (enc_code),
        .is_stcond (enc_stcond)
    );

    mem_issue_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .enc_code   (enc_code),
        .enc_stcond (enc_stcond),
        .link_ok    (link_ok),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_accept (cmd_accept),
        .port_retry (port_retry),
        .mem_resp   (mem_resp),
        .done_valid (done_valid),
        .done_fail  (done_fail),
        .retry_err  (retry_err)
    );

    assert_fail_only_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_fail |-> done_valid);
endmodule

// File: tb/mem_cmd_issuer_test.sv
// Directed bench for mem_cmd_issuer: one task per scenario.
// Inputs are driven at the falling edge and outputs sampled at the next falling edge.
module mem_cmd_issuer_test;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_llsc = 0, req_swap = 0, link_ok = 0;
    logic cmd_accept = 0, port_retry = 0, mem_resp = 0;
    logic req_ready, cmd_valid, done_valid, done_fail, retry_err;
    logic [2:0] cmd_code;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_cmd_issuer uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_llsc(req_llsc), .req_swap(req_swap),
        .link_ok(link_ok), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_accept(cmd_accept), .port_retry(port_retry), .mem_resp(mem_resp),
        .done_valid(done_valid), .done_fail(done_fail), .retry_err(retry_err)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Present one request for one cycle; returns after the command would appear.
    task automatic present(input logic w, input logic ll, input logic sw, input logic lk);
        req_valid = 1; req_write = w; req_llsc = ll; req_swap = sw; link_ok = lk;
        step();
        req_valid = 0; req_write = 0; req_llsc = 0; req_swap = 0; link_ok = 0;
    endtask

    // Full accepted access: checks code, pending hold, completion and status.
    task automatic full_access(input logic w, input logic ll, input logic sw, input logic lk,
                               input int exp_code, input string tag);
        present(w, ll, sw, lk);
        check(cmd_valid == 1 && cmd_code == exp_code, tag, cmd_code, exp_code);
        cmd_accept = 1;
        step();
        cmd_accept = 0;
        step();
        check(done_valid == 0 && cmd_valid == 0, "R8 pending holds", done_valid, 0);
        mem_resp = 1;
        step();
        mem_resp = 0;
        check(done_valid == 1 && done_fail == 0, {tag, " done"}, {done_valid, done_fail}, 2);
        step();
        check(req_ready == 1 && done_valid == 0, "R8 ready again", req_ready, 1);
    endtask

    task automatic t_reset();
        check(req_ready == 1, "R9 req_ready", req_ready, 1);
        check(cmd_valid == 0 && done_valid == 0 && retry_err == 0, "R9 outputs idle",
              {cmd_valid, done_valid, retry_err}, 0);
    endtask

    task automatic t_encodings();
        full_access(0, 0, 0, 0, 0, "R1 plain read");
        full_access(0, 1, 0, 0, 2, "R1 load-locked");
        full_access(0, 1, 1, 0, 2, "R1 read ignores swap");
        full_access(1, 0, 1, 0, 4, "R2 swap");
        full_access(1, 1, 1, 0, 4, "R2 swap over llsc");
        full_access(1, 0, 0, 0, 1, "R3 plain write");
        full_access(1, 1, 0, 1, 3, "R10 store-conditional ok");
    endtask

    task automatic t_sc_fail();
        present(1, 1, 0, 0);
        check(cmd_valid == 0, "R4 no command", cmd_valid, 0);
        check(done_valid == 1 && done_fail == 1, "R4 failed done", {done_valid, done_fail}, 3);
        step();
        check(done_valid == 0 && req_ready == 1, "R4 single pulse", done_valid, 0);
    endtask

    task automatic t_backpressure();
        present(1, 0, 0, 0);
        check(cmd_valid == 1 && cmd_code == 1, "R5 offered", cmd_code, 1);
        step();
        check(cmd_valid == 0 && done_valid == 0, "R5 blocked quiet", cmd_valid, 0);
        req_valid = 1; req_write = 0;
        step();
        step();
        check(req_ready == 0 && cmd_valid == 0, "R6 no new request", req_ready, 0);
        req_valid = 0;
        port_retry = 1;
        step();
        port_retry = 0;
        check(cmd_valid == 1 && cmd_code == 1, "R7 re-offered same code", cmd_code, 1);
        check(retry_err == 0, "R7 no error when blocked", retry_err, 0);
        cmd_accept = 1;
        step();
        cmd_accept = 0;
        mem_resp = 1;
        step();
        mem_resp = 0;
        check(done_valid == 1 && done_fail == 0, "R8 done after retry", done_valid, 1);
        step();
    endtask

    task automatic t_stray_retry();
        port_retry = 1;
        step();
        port_retry = 0;
        check(retry_err == 1, "R7 stray retry flagged", retry_err, 1);
        check(req_ready == 1 && cmd_valid == 0, "R7 stray retry no effect", cmd_valid, 0);
        step();
        check(retry_err == 0, "R7 error single pulse", retry_err, 0);
    endtask

    initial begin
        fork
            begin
                step(); step();
                rst_n = 1;
                step();
                t_reset();
                t_encodings();
                t_sc_fail();
                t_backpressure();
                t_stray_retry();
            end
            begin
                repeat (5000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule